// File: doc/BRIEF.md
# One-Time-Programmable Word Memory Model

This block is a clocked, synthesizable model of a word-wide read-only memory that is written once in the field. The storage is a register array of `DEPTH` words of `WIDTH` bits. A fresh or erased array holds all ones. Programming can only pull bits low, and only the erase input can raise them again. An active-low chip select `sel_n`, an active-low output gate `oe_gate_n` and a flag `vpp_on` together select one of six operating modes. The data output is modelled as a data bus `dout` plus a drive-enable `dout_drv` that stands in for a three-state pin. When the drive is off, `dout` is forced to zero.

The mode decode is combinational. The read path is registered, so `dout_drv` and `dout` follow the mode and address sampled at the previous clock edge. The six modes, keyed on (`vpp_on`, `sel_n`, `oe_gate_n`), are:

| Mode | vpp_on | sel_n | oe_gate_n | Effect |
|---|---|---|---|---|
| MD_STANDBY | 0 | 1 | any | output off |
| MD_READ | 0 | 0 | 0 | addressed word driven |
| MD_OUT_OFF | 0 | 0 | 1 | output off |
| MD_PROGRAM | 1 | 0 | any | program pulse may run |
| MD_VERIFY | 1 | 1 | 0 | addressed word driven |
| MD_INHIBIT | 1 | 1 | 1 | output off, no write |

A program pulse is a count of clock edges, handled by a small state machine with three states. `PS_IDLE` waits for a pulse to start. `PS_COUNT` measures the pulse. `PS_HOLD` waits out the rest of a pulse that has finished or been rejected. The transitions are:

- **start** (`PS_IDLE`→`PS_COUNT`): `sel_n` is low while `vpp_on` is high. The address and data are captured on this edge.
- **tick** (`PS_COUNT`→`PS_COUNT`): the pulse is still low and unchanged, but not yet long enough.
- **short** (`PS_COUNT`→`PS_IDLE`): `sel_n` rises before the pulse is long enough.
- **commit** (`PS_COUNT`→`PS_HOLD`): the pulse reaches the required length, and the word is written on this edge.
- **abort** (`PS_COUNT`→`PS_HOLD`): the address or data changes, or `vpp_on` drops, during the pulse.
- **release** (`PS_HOLD`→`PS_IDLE`): `sel_n` goes high.

`PGM_CYCLES` must be at least 2.

Top module: `otp_word_mem`

## Requirements
- R1: After reset every word reads 16'hFFFF. One clock edge with `erase`=1 and `vpp_on`=0 makes every word read 16'hFFFF.
- R2: A committed program stores the bitwise AND of the old word and `din`. A requested 0-to-1 bit change is ignored.
- R3: With `sel_n`=1 and `vpp_on`=0, `dout_drv` is 0 and `dout` is 0 one cycle later.
- R4: With `vpp_on`=0, `sel_n`=0 and `oe_gate_n`=0, `dout_drv`=1 one cycle later and `dout` holds the word at the sampled address. With `oe_gate_n`=1 instead, `dout_drv` is 0.
- R5: A word is written only when `sel_n` has been low, with `vpp_on` high, for `PGM_CYCLES` consecutive clock edges. It is written on the last of those edges. A shorter pulse leaves the array unchanged.
- R6: If `addr` or `din` changes, or `vpp_on` falls, during a pulse, the pulse is rejected. Nothing is written until `sel_n` returns high and a new pulse begins.
- R7: A pulse writes at most once. Changing `din` after the commit while `sel_n` is still low has no effect.
- R8: With `vpp_on`=1, `sel_n`=1 and `oe_gate_n`=0, the addressed word is driven one cycle later, with `dout_drv`=1.
- R9: With `vpp_on`=1 and `sel_n`=`oe_gate_n`=1, nothing is written and `dout_drv` is 0.
- R10: `erase` has no effect while `vpp_on`=1.
- R11: With `vpp_on`=1 and `sel_n`=0, `dout_drv` is 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; array to all ones, FSM to PS_IDLE |
| sel_n | input | 1 | Active-low chip select; its low time is the program pulse |
| oe_gate_n | input | 1 | Active-low output gate |
| vpp_on | input | 1 | Program voltage present |
| erase | input | 1 | Set every word to all ones (ignored while vpp_on=1) |
| addr | input | $clog2(DEPTH) | Word address |
| din | input | WIDTH | Program data |
| dout | output | WIDTH | Registered read data, zero when not driven |
| dout_drv | output | 1 | Output drive enable (three-state stand-in) |

## Verification
The hardest case to reach from the ports is a pulse that is long enough but is spoiled mid-way. The bench holds `sel_n` low past `PGM_CYCLES` edges while it changes the address on the second edge. It then reads back both addresses to show that neither changed. A second hard case is a second write within one pulse. To reach it, the bench swaps `din` to all zeros after the commit edge while `sel_n` stays low. It then shows that only the first pattern was ANDed in. Short pulses of `PGM_CYCLES-1` edges and exact pulses of `PGM_CYCLES` edges are both driven, so the write edge is located to within one clock.

// File: rtl/otp_pkg.sv
package otp_pkg;
    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_OUT_OFF,
        MD_PROGRAM,
        MD_VERIFY,
        MD_INHIBIT
    } mode_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_COUNT,
        PS_HOLD
    } pstate_t;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_pkg::*;
(
    input  logic  sel_n,
    input  logic  oe_gate_n,
    input  logic  vpp_on,
    output mode_t mode,
    output logic  read_req
);
    always_comb begin
        unique case ({vpp_on, sel_n, oe_gate_n})
            3'b000:  mode = MD_READ;
            3'b001:  mode = MD_OUT_OFF;
            3'b010,
            3'b011:  mode = MD_STANDBY;
            3'b100,
            3'b101:  mode = MD_PROGRAM;
            3'b110:  mode = MD_VERIFY;
            default: mode = MD_INHIBIT;
        endcase
    end

    assign read_req = (mode == MD_READ) || (mode == MD_VERIFY);
endmodule

// File: rtl/otp_pulse_fsm.sv
module otp_pulse_fsm
    import otp_pkg::*;
#(
    parameter int AW         = 6,
    parameter int WIDTH      = 16,
    parameter int PGM_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             vpp_on,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [WIDTH-1:0] wr_data
);
    localparam int CW = $clog2(PGM_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PGM_CYCLES - 1);

    pstate_t          state, state_nx;
    logic [CW-1:0]    cnt, cnt_nx;
    logic [AW-1:0]    cap_addr, cap_addr_nx;
    logic [WIDTH-1:0] cap_data, cap_data_nx;
    logic             spoiled;

    assign spoiled = !vpp_on || (addr != cap_addr) || (din != cap_data);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= PS_IDLE;
            cnt      <= '0;
            cap_addr <= '0;
            cap_data <= '0;
        end else begin
            state    <= state_nx;
            cnt      <= cnt_nx;
            cap_addr <= cap_addr_nx;
            cap_data <= cap_data_nx;
        end
    end

    // next state and outputs
    always_comb begin
        state_nx    = state;
        cnt_nx      = cnt;
        cap_addr_nx = cap_addr;
        cap_data_nx = cap_data;
        wr_en       = 1'b0;
        unique case (state)
            PS_IDLE: begin
                if (!sel_n && vpp_on) begin      // start
                    state_nx    = PS_COUNT;
                    cnt_nx      = CW'(1);
                    cap_addr_nx = addr;
                    cap_data_nx = din;
                end
            end
            PS_COUNT: begin
                if (sel_n) begin                 // short
                    state_nx = PS_IDLE;
                    cnt_nx   = '0;
                end else if (spoiled) begin      // abort
                    state_nx = PS_HOLD;
                    cnt_nx   = '0;
                end else if (cnt == LAST) begin  // commit
                    state_nx = PS_HOLD;
                    cnt_nx   = '0;
                    wr_en    = 1'b1;
                end else begin                   // tick
                    cnt_nx = cnt + CW'(1);
                end
            end
            PS_HOLD: begin
                if (sel_n) state_nx = PS_IDLE;   // release
            end
            default: state_nx = PS_IDLE;
        endcase
    end

    assign wr_addr = cap_addr;
    assign wr_data = cap_data;

    // checker: consecutive low edges seen before the current one
    logic [CW-1:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           low_run <= '0;
        else if (sel_n || !vpp_on)            low_run <= '0;
        else if (low_run != CW'(PGM_CYCLES))  low_run <= low_run + CW'(1);
    end

    assert_full_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!sel_n && vpp_on && low_run >= LAST));

    assert_single_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    assert_stable_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (addr == wr_addr && din == wr_data));
endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             erase_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_drv
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_drv  <= 1'b0;
        end else begin
            rd_drv  <= rd_en;
            rd_data <= rd_en ? mem[rd_addr] : '0;
        end
    end

    // checker support
    logic             all_ones;
    logic [AW-1:0]    chk_addr;
    logic [WIDTH-1:0] chk_old;
    logic             chk_v;

    always_comb begin
        all_ones = 1'b1;
        for (int i = 0; i < DEPTH; i++) all_ones = all_ones & (&mem[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_v    <= 1'b0;
            chk_addr <= '0;
            chk_old  <= '0;
        end else begin
            chk_v    <= wr_en;
            chk_addr <= wr_addr;
            chk_old  <= mem[wr_addr];
        end
    end

    assert_no_bit_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        chk_v |-> ((mem[chk_addr] & ~chk_old) == '0));

    assert_erase_all_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |=> all_ones);
endmodule

// File: rtl/otp_word_mem.sv
module otp_word_mem
    import otp_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int WIDTH      = 16,
    parameter int PGM_CYCLES = 4,
    localparam int AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_n,
    input  logic             oe_gate_n,
    input  logic             vpp_on,
    input  logic             erase,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             dout_drv
);
    mode_t            mode;
    logic             read_req;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [WIDTH-1:0] wr_data;
    logic             erase_en;

    assign erase_en = erase && !vpp_on;

    otp_mode_decode u_dec (
        .sel_n     (sel_n),
        .oe_gate_n (oe_gate_n),
        .vpp_on    (vpp_on),
        .mode      (mode),
        .read_req  (read_req)
    );

    otp_pulse_fsm #(.AW(AW), .WIDTH(WIDTH), .PGM_CYCLES(PGM_CYCLES)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .vpp_on  (vpp_on),
        .addr    (addr),
        .din     (din),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    otp_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .erase_en (erase_en),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (read_req),
        .rd_addr  (addr),
        .rd_data  (dout),
        .rd_drv   (dout_drv)
    );

    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !vpp_on) |=> (!dout_drv && dout == '0));

    assert_read_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !oe_gate_n && !vpp_on) |=> dout_drv);

    assert_verify_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && !oe_gate_n && vpp_on) |=> dout_drv);

    assert_inhibit_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_n && oe_gate_n && vpp_on) |-> !wr_en);

    assert_program_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && vpp_on) |=> !dout_drv);
endmodule

// File: tb/tb_otp_word_mem.sv
module tb_otp_word_mem;
    localparam int DEPTH = 64;
    localparam int WIDTH = 16;
    localparam int PGM   = 4;
    localparam int AW    = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, oe_gate_n = 1'b1, vpp_on = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [WIDTH-1:0] din = '0;
    logic [WIDTH-1:0] dout;
    logic dout_drv;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [WIDTH-1:0] model [DEPTH];

    always #2 clk = ~clk;

    otp_word_mem #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PGM_CYCLES(PGM)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .oe_gate_n(oe_gate_n),
        .vpp_on(vpp_on), .erase(erase), .addr(addr), .din(din),
        .dout(dout), .dout_drv(dout_drv)
    );

    task automatic chk(input string req, input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_word(input logic [AW-1:0] a, output logic [WIDTH-1:0] d, output logic drv);
        @(negedge clk);
        vpp_on = 1'b0; sel_n = 1'b0; oe_gate_n = 1'b0; addr = a;
        @(negedge clk);
        d = dout; drv = dout_drv;
    endtask

    task automatic check_word(input string req, input logic [AW-1:0] a);
        logic [WIDTH-1:0] d; logic drv;
        read_word(a, d, drv);
        chk(req, {15'd0, drv}, 16'd1);
        chk(req, d, model[a]);
    endtask

    // pulse of len low edges; returns with sel_n high and FSM idle
    task automatic pulse(input logic [AW-1:0] a, input logic [WIDTH-1:0] d, input int len);
        @(negedge clk);
        vpp_on = 1'b1; sel_n = 1'b1; oe_gate_n = 1'b1; addr = a; din = d;
        @(negedge clk);
        sel_n = 1'b0;
        repeat (len) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R3 reset drive", {15'd0, dout_drv}, 16'd0);
        check_word("R1 reset word0", 0);
        check_word("R1 reset last", AW'(DEPTH - 1));
        check_word("R1 reset mid", 17);
    endtask

    task automatic t_standby;
        @(negedge clk); vpp_on = 1'b0; sel_n = 1'b1; oe_gate_n = 1'b0; addr = 0;
        @(negedge clk);
        chk("R3 standby drive", {15'd0, dout_drv}, 16'd0);
        chk("R3 standby data", dout, 16'd0);
        @(negedge clk); sel_n = 1'b0; oe_gate_n = 1'b1;
        @(negedge clk);
        chk("R4 gate off drive", {15'd0, dout_drv}, 16'd0);
    endtask

    task automatic t_program;
        pulse(3, 16'hA5F0, PGM);
        model[3] = model[3] & 16'hA5F0;
        check_word("R5 exact pulse", 3);
        pulse(3, 16'h0FFF, PGM + 2);
        model[3] = model[3] & 16'h0FFF;
        check_word("R2 and-merge", 3);
        pulse(3, 16'hFFFF, PGM);
        check_word("R2 no rise", 3);
        pulse(AW'(DEPTH - 1), 16'h1234, PGM);
        model[DEPTH-1] = 16'h1234;
        check_word("R5 last addr", AW'(DEPTH - 1));
    endtask

    task automatic t_short;
        pulse(5, 16'h0000, PGM - 1);
        check_word("R5 short pulse", 5);
        pulse(5, 16'h0000, 1);
        check_word("R5 one edge", 5);
    endtask

    task automatic t_abort;
        @(negedge clk);
        vpp_on = 1'b1; sel_n = 1'b1; oe_gate_n = 1'b1; addr = 8; din = 16'h0000;
        @(negedge clk); sel_n = 1'b0;
        @(negedge clk);
        @(negedge clk); addr = 9;
        repeat (PGM + 2) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check_word("R6 addr change first", 8);
        check_word("R6 addr change second", 9);
        @(negedge clk);
        vpp_on = 1'b1; sel_n = 1'b1; addr = 10; din = 16'h00FF;
        @(negedge clk); sel_n = 1'b0;
        @(negedge clk); din = 16'h0F0F;
        repeat (PGM + 2) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check_word("R6 data change", 10);
        @(negedge clk);
        vpp_on = 1'b1; sel_n = 1'b1; addr = 11; din = 16'h0000;
        @(negedge clk); sel_n = 1'b0;
        @(negedge clk); vpp_on = 1'b0;
        @(negedge clk); vpp_on = 1'b1;
        repeat (PGM + 2) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check_word("R6 vpp drop", 11);
    endtask

    task automatic t_single;
        @(negedge clk);
        vpp_on = 1'b1; sel_n = 1'b1; oe_gate_n = 1'b1; addr = 20; din = 16'hF00F;
        @(negedge clk); sel_n = 1'b0;
        repeat (PGM) @(negedge clk);
        din = 16'h0000;
        chk("R11 program drive", {15'd0, dout_drv}, 16'd0);
        repeat (3) @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk); @(negedge clk);
        model[20] = 16'hF00F;
        check_word("R7 one write", 20);
    endtask

    task automatic t_verify;
        @(negedge clk); vpp_on = 1'b1; sel_n = 1'b1; oe_gate_n = 1'b0; addr = 3;
        @(negedge clk);
        chk("R8 verify drive", {15'd0, dout_drv}, 16'd1);
        chk("R8 verify data", dout, model[3]);
    endtask

    task automatic t_inhibit;
        @(negedge clk); vpp_on = 1'b1; sel_n = 1'b1; oe_gate_n = 1'b1; addr = 30; din = 16'h0000;
        repeat (PGM + 3) @(negedge clk);
        chk("R9 inhibit drive", {15'd0, dout_drv}, 16'd0);
        check_word("R9 inhibit word", 30);
    endtask

    task automatic t_erase;
        @(negedge clk); vpp_on = 1'b1; sel_n = 1'b1; oe_gate_n = 1'b1; erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        check_word("R10 erase ignored", 3);
        check_word("R10 erase ignored last", AW'(DEPTH - 1));
        @(negedge clk); vpp_on = 1'b0; sel_n = 1'b1; erase = 1'b1;
        @(negedge clk); erase = 1'b0;
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        check_word("R1 erase word3", 3);
        check_word("R1 erase word20", 20);
        check_word("R1 erase last", AW'(DEPTH - 1));
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_standby();
        t_program();
        t_short();
        t_abort();
        t_single();
        t_verify();
        t_inhibit();
        t_erase();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule